// File: doc/BRIEF.md
# PS/2 Keyboard Key Event Decoder

This block listens to the two open-collector lines of a PS/2 keyboard (clock and data), brings them into the system clock domain and cleans them, and assembles the 11-bit frames the keyboard sends. Frames with a bad start, parity or stop bit raise a one-cycle error pulse and are thrown away. A frame left unfinished for too long is dropped without any pulse.

Good bytes go to a small prefix state machine. It folds the extended-key byte (0xE0) and the release byte (0xF0) into flags. When the next ordinary byte arrives, it emits one key event: the scan code, an extended flag, a release flag and a one-cycle valid pulse. The consumer therefore sees one event per key action and never sees the prefix bytes. Held keys repeat their make code, and each repeat becomes its own event.

The prefix state machine has four states. KS_IDLE means no prefix is pending. KS_EXT means an extended prefix was seen. KS_BRK means a release prefix was seen. KS_EXT_BRK means both were seen, with the extended prefix first. Its transitions:
- Byte 0xE0 in any state goes to KS_EXT.
- Byte 0xF0 goes to KS_BRK from KS_IDLE or KS_BRK, and to KS_EXT_BRK from KS_EXT or KS_EXT_BRK.
- Any other byte emits an event and returns to KS_IDLE.
- A bad frame returns to KS_IDLE from any state.

Top module: `ps2_key_decoder`

## Requirements
- R1: While reset is held and right after it, `evt_valid` and `frame_err` stay low.
- R2: A frame is a 0 start bit, then 8 data bits least significant bit first, then an odd parity bit (the 9 bits data+parity hold an odd number of ones), then a 1 stop bit. Bits are taken at falling edges of the PS/2 clock line. A good frame carrying a byte other than 0xE0 or 0xF0, with no prefix pending, gives one event with that code, `evt_ext`=0 and `evt_brk`=0.
- R3: Byte 0xF0 followed by a code gives one event with `evt_brk`=1 and `evt_ext`=0.
- R4: Byte 0xE0 followed by a code gives one event with `evt_ext`=1 and `evt_brk`=0.
- R5: Bytes 0xE0, 0xF0 and then a code give one event with `evt_ext`=1 and `evt_brk`=1.
- R6: Prefix bytes alone produce no event. The prefix flags clear after each event, so a following plain code reports both flags as 0.
- R7: A frame whose parity is even gives a `frame_err` pulse and no event, and it clears any pending prefix.
- R8: A frame with a start bit of 1 or a stop bit of 0 gives a `frame_err` pulse and no event.
- R9: If no falling edge arrives for `TIMEOUT_CYC` system cycles in the middle of a frame, the partial frame is dropped with no pulse, and the next full frame is decoded normally.
- R10: A low pulse on the PS/2 clock line shorter than `FILT_LEN` system cycles is not counted as a falling edge.
- R11: A code repeated several times gives one make event per repeat.
- R12: `evt_valid` and `frame_err` are single-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | PS/2 clock line as read from the pad |
| ps2_dat_i | input | 1 | PS/2 data line as read from the pad |
| evt_valid | output | 1 | One-cycle pulse when a key event is output |
| evt_code | output | 8 | Scan code of the event |
| evt_ext | output | 1 | Event belongs to an extended key |
| evt_brk | output | 1 | Event is a key release (0 means press) |
| frame_err | output | 1 | One-cycle pulse for a frame with a bad start, parity or stop bit |

## Verification
The bench drives whole frames and covers each prefix pattern: plain codes, release, extended, and extended release. It also sends a run of identical codes to show that repeats are reported, and a plain code right after each prefixed event to show that the flags clear. Corrupted frames are checked in three forms (flipped parity, high start bit, low stop bit). One of them is placed after a pending extended prefix, which tells apart a decoder that clears prefixes on error from one that keeps them. A frame cut short by a long pause, and a brief glitch on the idle clock line, tell apart a decoder that drops partial frames and filters edges from one that would misalign every later bit.

// File: rtl/ps2_kbd_pkg.sv
package ps2_kbd_pkg;
    localparam int FRAME_BITS = 11;
    localparam logic [7:0] CODE_EXT = 8'hE0;
    localparam logic [7:0] CODE_BRK = 8'hF0;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_EXT,
        KS_BRK,
        KS_EXT_BRK
    } kstate_t;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchronizer, then a level that follows the input only
    // after FILT_LEN consecutive cycles of disagreement.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            level_o <= 1'b1;
            cnt_q   <= '0;
            fall_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            fall_o <= 1'b0;
            if (sync_q[1] == level_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                level_o <= sync_q[1];
                cnt_q   <= '0;
                fall_o  <= level_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_kbd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fall_i,
    input  logic       dat_i,
    output logic       byte_stb_o,
    output logic [7:0] byte_o,
    output logic       err_o
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [BW-1:0]         bit_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [TW-1:0]         tmo_q;
    logic [FRAME_BITS-1:0] frame_w;
    logic                  frame_ok;

    assign frame_w  = {dat_i, sh_q[FRAME_BITS-1:1]};
    assign frame_ok = !frame_w[0] && frame_w[FRAME_BITS-1] && (^frame_w[9:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q      <= '0;
            sh_q       <= '0;
            tmo_q      <= '0;
            byte_stb_o <= 1'b0;
            byte_o     <= '0;
            err_o      <= 1'b0;
        end else begin
            byte_stb_o <= 1'b0;
            err_o      <= 1'b0;
            if (fall_i) begin
                tmo_q <= '0;
                sh_q  <= frame_w;
                if (bit_q == BW'(FRAME_BITS - 1)) begin
                    bit_q      <= '0;
                    byte_stb_o <= frame_ok;
                    err_o      <= !frame_ok;
                    byte_o     <= frame_w[8:1];
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end else if (bit_q != '0) begin
                if (tmo_q == TW'(TIMEOUT_CYC - 1)) begin
                    bit_q <= '0;
                    tmo_q <= '0;
                end else begin
                    tmo_q <= tmo_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_event_fsm.sv
module ps2_event_fsm
    import ps2_kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_stb_i,
    input  logic [7:0] byte_i,
    input  logic       err_i,
    output logic       evt_valid_o,
    output logic [7:0] evt_code_o,
    output logic       evt_ext_o,
    output logic       evt_brk_o
);
    kstate_t state_q, state_d;
    logic    is_prefix;

    assign is_prefix = (byte_i == CODE_EXT) || (byte_i == CODE_BRK);

    always_comb begin
        state_d = state_q;
        if (err_i) begin
            state_d = KS_IDLE;
        end else if (byte_stb_i) begin
            if (byte_i == CODE_EXT) begin
                state_d = KS_EXT;
            end else if (byte_i == CODE_BRK) begin
                unique case (state_q)
                    KS_IDLE, KS_BRK:    state_d = KS_BRK;
                    KS_EXT, KS_EXT_BRK: state_d = KS_EXT_BRK;
                    default:            state_d = KS_IDLE;
                endcase
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid_o <= 1'b0;
            evt_code_o  <= '0;
            evt_ext_o   <= 1'b0;
            evt_brk_o   <= 1'b0;
        end else begin
            evt_valid_o <= 1'b0;
            if (byte_stb_i && !is_prefix) begin
                evt_valid_o <= 1'b1;
                evt_code_o  <= byte_i;
                unique case (state_q)
                    KS_IDLE:    begin evt_ext_o <= 1'b0; evt_brk_o <= 1'b0; end
                    KS_EXT:     begin evt_ext_o <= 1'b1; evt_brk_o <= 1'b0; end
                    KS_BRK:     begin evt_ext_o <= 1'b0; evt_brk_o <= 1'b1; end
                    KS_EXT_BRK: begin evt_ext_o <= 1'b1; evt_brk_o <= 1'b1; end
                    default:    begin evt_ext_o <= 1'b0; evt_brk_o <= 1'b0; end
                endcase
            end
        end
    end
endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder #(
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       evt_valid,
    output logic [7:0] evt_code,
    output logic       evt_ext,
    output logic       evt_brk,
    output logic       frame_err
);
    logic       clk_lvl, clk_fall;
    logic       dat_lvl, dat_fall;
    logic       byte_stb;
    logic [7:0] byte_val;

    ps2_line_filter #(.FILT_LEN(FILT_LEN)) i_clk_filt (
        .clk(clk), .rst(rst), .line_i(ps2_clk_i),
        .level_o(clk_lvl), .fall_o(clk_fall)
    );

    ps2_line_filter #(.FILT_LEN(FILT_LEN)) i_dat_filt (
        .clk(clk), .rst(rst), .line_i(ps2_dat_i),
        .level_o(dat_lvl), .fall_o(dat_fall)
    );

    ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_rx (
        .clk(clk), .rst(rst), .fall_i(clk_fall), .dat_i(dat_lvl),
        .byte_stb_o(byte_stb), .byte_o(byte_val), .err_o(frame_err)
    );

    ps2_event_fsm i_fsm (
        .clk(clk), .rst(rst),
        .byte_stb_i(byte_stb), .byte_i(byte_val), .err_i(frame_err),
        .evt_valid_o(evt_valid), .evt_code_o(evt_code),
        .evt_ext_o(evt_ext), .evt_brk_o(evt_brk)
    );

    logic unused_ok;
    assign unused_ok = &{1'b0, clk_lvl, dat_fall};
endmodule

// File: rtl/ps2_key_decoder_chk.sv
module ps2_key_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       evt_valid,
    input logic [7:0] evt_code,
    input logic       frame_err,
    input logic       byte_stb
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !evt_valid); // R12
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err); // R12
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(evt_valid && frame_err)); // R12
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!evt_valid && !frame_err)); // R1
    AST_NO_PREFIX_EVT: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code != 8'hE0 && evt_code != 8'hF0)); // R6
    AST_EVT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(byte_stb)); // R2
endmodule

bind ps2_key_decoder ps2_key_decoder_chk i_chk (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .frame_err(frame_err), .byte_stb(byte_stb)
);

// File: tb/test_ps2_key_decoder.sv
module test_ps2_key_decoder;
    localparam int HALF = 40;
    localparam int TMO  = 12500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ps2_clk = 1'b1;
    logic ps2_dat = 1'b1;
    logic       evt_valid, evt_ext, evt_brk, frame_err;
    logic [7:0] evt_code;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int err_pend = 0;
    bit m_ext = 1'b0;
    bit m_brk = 1'b0;
    bit prev_v = 1'b0;
    bit prev_e = 1'b0;
    logic [9:0] expq[$];

    always #4 clk = ~clk;

    ps2_key_decoder #(.FILT_LEN(4), .TIMEOUT_CYC(TMO)) i_ps2_key_decoder (
        .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_ext(evt_ext),
        .evt_brk(evt_brk), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare every clock against the behavioural model's queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (evt_valid) begin
                check(!prev_v, "R12 valid pulse width", 16'(prev_v), 16'd0);
                check(!frame_err, "R12 valid with err", 16'(frame_err), 16'd0);
                if (expq.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected event", {6'd0, evt_code, evt_ext, evt_brk}, 16'd0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    check({evt_code, evt_ext, evt_brk} == e, "R2/R3/R4/R5/R11 event",
                          {6'd0, evt_code, evt_ext, evt_brk}, {6'd0, e});
                end
            end
            if (frame_err) begin
                check(!prev_e, "R12 err pulse width", 16'(prev_e), 16'd0);
                check(err_pend > 0, "R7/R8/R9/R10 error pulse", 16'd1, 16'(err_pend));
                if (err_pend > 0) err_pend--;
            end
        end
        prev_v = evt_valid;
        prev_e = frame_err;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 200000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 200000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_start, input bit bad_stop);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
        for (int i = 0; i < 11; i++) begin
            ps2_dat = f[i];
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    // Behavioural model of the byte stream.
    task automatic key_byte(input logic [7:0] b);
        if (b == 8'hE0) begin
            m_ext = 1'b1;
            m_brk = 1'b0;
        end else if (b == 8'hF0) begin
            m_brk = 1'b1;
        end else begin
            expq.push_back({b, m_ext, m_brk});
            m_ext = 1'b0;
            m_brk = 1'b0;
        end
        send_frame(b, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic bad_frame(input logic [7:0] b, input bit p, input bit s, input bit t);
        m_ext = 1'b0;
        m_brk = 1'b0;
        err_pend++;
        send_frame(b, p, s, t);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(!evt_valid && !frame_err, "R1 during reset", {evt_valid, frame_err}, 16'd0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(!evt_valid && !frame_err, "R1 after reset", {evt_valid, frame_err}, 16'd0);

        key_byte(8'h1C);                                    // R2 plain
        key_byte(8'h5A);                                    // R2
        key_byte(8'hF0); key_byte(8'h1C);                   // R3 release
        key_byte(8'h29);                                    // R6 flags cleared
        key_byte(8'hE0); key_byte(8'h75);                   // R4 extended
        key_byte(8'h33);                                    // R6
        key_byte(8'hE0); key_byte(8'hF0); key_byte(8'h75);  // R5 extended release
        key_byte(8'h01);                                    // R6
        key_byte(8'h23); key_byte(8'h23); key_byte(8'h23);  // R11 repeats

        key_byte(8'hE0);                                    // R7 prefix then bad parity
        bad_frame(8'h4B, 1'b1, 1'b0, 1'b0);
        key_byte(8'h4B);                                    // must be plain
        bad_frame(8'h66, 1'b0, 1'b1, 1'b0);                 // R8 bad start
        key_byte(8'h66);
        bad_frame(8'h12, 1'b0, 1'b0, 1'b1);                 // R8 bad stop
        key_byte(8'h12);

        // R9 partial frame: four bits then a long pause
        for (int i = 0; i < 4; i++) begin
            ps2_dat = (i == 0) ? 1'b0 : 1'b1;
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        repeat (TMO + 500) @(negedge clk);
        key_byte(8'h3A);

        // R10 short glitch on idle clock line
        ps2_clk = 1'b0;
        repeat (2) @(negedge clk);
        ps2_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        key_byte(8'h4D);
        key_byte(8'hF0); key_byte(8'h4D);

        repeat (200) @(negedge clk);
        check(expq.size() == 0, "R2-R11 all events seen", 16'(expq.size()), 16'd0);
        check(err_pend == 0, "R7 R8 all errors seen", 16'(err_pend), 16'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule